// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Option

This block buffers 9-bit words between two unrelated clock domains. The producer writes on its own clock and the consumer reads on another. The storage depth is a power of two, set by a parameter. While master reset is held low, the block captures one of two read behaviours. In standard mode the consumer must ask for every word, including the first, with a read enable. In fall-through mode the oldest word is placed on the output by itself, and the read enable only acknowledges that word. An output stage holds that word, so fall-through mode stores one word more than the memory array.

Both pointers cross into the other domain as Gray code through two-stage synchronizers. The write side computes the space flag, the almost-full flag and the half-full flag. The read side computes the data-available flag and the almost-empty flag. The almost-empty and almost-full thresholds come in as inputs from a separate offset-loading block. A partial reset empties the buffer but keeps the timing mode that was captured.

Top module: `tcf_fifo`

## Requirements
- R1: The timing mode is captured from `ft_sel` only while `mrst_n` is low: 0 selects standard mode and 1 selects fall-through mode. A change of `ft_sel` at any other time, including during a partial reset, has no effect.
- R2: After master reset the buffer holds no words. In standard mode `wr_flag`=1 and `rd_flag`=0. In fall-through mode `wr_flag`=0 and `rd_flag`=1. In both modes `half_n`=1, `afull_n`=1 and `aempty_n`=0.
- R3: In standard mode, `rd_flag`=1 means at least one word is stored. Each `rd_clk` edge with `rd_en`=1 and a word stored pops the oldest word, which appears on `rd_data` after that edge. Without such an edge, `rd_data` does not change. Words leave in the order they were written.
- R4: In fall-through mode, `rd_flag`=0 means the oldest word is already on `rd_data`, with no read enable needed. A `rd_clk` edge with `rd_en`=1 while `rd_flag`=0 consumes that word. While `rd_en`=0, the word and `rd_flag` stay as they are.
- R5: In standard mode the buffer accepts D = 2^AW words and then shows `wr_flag`=0. In fall-through mode it accepts D+1 words and then shows `wr_flag`=1. Writes beyond capacity are dropped.
- R6: A read when no word is available is ignored. `rd_data` is unchanged, and the next word written is the next word read.
- R7: `afull_n` is 0 when the array count is at least D - `af_off`. The array count is the number of stored words, excluding the word held at the output in fall-through mode.
- R8: `aempty_n` is 0 when the array count is at most `ae_off`.
- R9: `half_n` is 0 when the array count is greater than D/2.
- R10: A partial reset (`prst_n` low) discards all stored words and returns the flags to their R2 values for the mode already captured. The captured mode is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low; captures the mode |
| prst_n | input | 1 | Partial reset, active low; keeps the mode |
| ft_sel | input | 1 | Mode select, sampled during master reset (1 = fall-through) |
| wr_en | input | 1 | Write enable |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Read enable (standard) or acknowledge (fall-through) |
| rd_data | output | DW | Read data |
| ae_off | input | AW | Almost-empty threshold |
| af_off | input | AW | Almost-full threshold |
| wr_flag | output | 1 | Standard: 1 = not full. Fall-through: 0 = space available |
| rd_flag | output | 1 | Standard: 1 = not empty. Fall-through: 0 = word ready |
| half_n | output | 1 | Low when the array count is above D/2 |
| aempty_n | output | 1 | Low when the array count is at or below `ae_off` |
| afull_n | output | 1 | Low when the array count is at or above D - `af_off` |

## Verification
The assertions assume the following about the inputs:
- `mrst_n` stays low across several edges of both clocks, so that the two domain copies of the mode agree.
- `ae_off` and `af_off` are stable while traffic flows.
- Enables change away from the sampling edges.

The bench holds reset low for four read-clock edges and fixes the thresholds before each phase. It drives every input on the falling edge of the clock that samples it. In the random phases it writes only when the space flag allows a write, and it reads only when the data flag allows a read. Flag levels are compared only after both clocks have run long enough for the synchronized pointers to settle.

// File: rtl/tcf_pkg.sv
package tcf_pkg;
  typedef enum logic {TM_STD = 1'b0, TM_FALL = 1'b1} tmode_e;

  // binary to reflected Gray
  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // reflected Gray back to binary by prefix xor
  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int s = 1; s < 32; s = s * 2) b = b ^ (b >> s);
    return b;
  endfunction
endpackage

// File: rtl/tcf_sync2.sv
module tcf_sync2 #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/tcf_ram.sv
module tcf_ram #(
  parameter int DW = 9,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  // registered read port: this is the output register in both modes
  always_ff @(posedge rclk) begin
    if (re) rdata <= cells[raddr];
  end
endmodule

// File: rtl/tcf_wside.sv
module tcf_wside
  import tcf_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          rst_n,
  input  logic          ft_sel,
  input  logic          wr_en,
  input  logic [AW-1:0] af_off,
  input  logic [AW:0]   rgray_s,
  output logic [AW-1:0] waddr,
  output logic          push,
  output logic [AW:0]   wgray,
  output logic          wr_flag,
  output logic          afull_n,
  output logic          half_n
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  tmode_e          mode;
  logic [PW-1:0]   wbin;
  logic [PW-1:0]   rbin_s;
  logic [PW-1:0]   wcount;
  logic            full;

  // mode copy for this domain, loaded only under master reset
  always_ff @(posedge clk) begin
    if (!mrst_n) mode <= tmode_e'(ft_sel);
  end

  assign rbin_s = PW'(from_gray(32'(rgray_s)));
  assign wcount = wbin - rbin_s;
  assign full   = (wcount == PW'(DEPTH));
  assign push   = wr_en & ~full;
  assign waddr  = wbin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (push) begin
      wbin  <= wbin + 1'b1;
      wgray <= PW'(to_gray(32'(wbin + 1'b1)));
    end
  end

  assign wr_flag = (mode == TM_FALL) ? full : ~full;
  assign afull_n = ~(wcount >= (PW'(DEPTH) - PW'(af_off)));
  assign half_n  = ~(wcount > PW'(DEPTH / 2));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) wcount <= PW'(DEPTH)) else $error("write count beyond depth"); // R5
  AST_FULL_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && full) |=> (wbin == $past(wbin))) else $error("write pointer moved while full"); // R5
  AST_MODE_FROZEN_W: assert property (@(posedge clk) disable iff (!mrst_n) mrst_n |=> $stable(mode)) else $error("write-side mode changed outside master reset"); // R1
endmodule

// File: rtl/tcf_rside.sv
module tcf_rside
  import tcf_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          rst_n,
  input  logic          ft_sel,
  input  logic          rd_en,
  input  logic [AW-1:0] ae_off,
  input  logic [AW:0]   wgray_s,
  output logic          ram_re,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          fall_mode,
  output logic          rd_flag,
  output logic          aempty_n
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  tmode_e          mode;
  logic [PW-1:0]   rbin;
  logic [PW-1:0]   wbin_s;
  logic [PW-1:0]   rcount;
  logic            ram_empty;
  logic            ovalid;
  logic            take;

  always_ff @(posedge clk) begin
    if (!mrst_n) mode <= tmode_e'(ft_sel);
  end

  assign fall_mode = (mode == TM_FALL);
  assign wbin_s    = PW'(from_gray(32'(wgray_s)));
  assign rcount    = wbin_s - rbin;
  assign ram_empty = (rcount == '0);

  // a word leaves the array on a request (standard) or to refill the output (fall-through)
  always_comb begin
    if (fall_mode) take = ~ram_empty & (~ovalid | rd_en);
    else           take = rd_en & ~ram_empty;
  end

  assign ram_re = take;
  assign raddr  = rbin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin   <= '0;
      rgray  <= '0;
      ovalid <= 1'b0;
    end else begin
      if (take) begin
        rbin  <= rbin + 1'b1;
        rgray <= PW'(to_gray(32'(rbin + 1'b1)));
      end
      if (fall_mode) begin
        if (take)       ovalid <= 1'b1;
        else if (rd_en) ovalid <= 1'b0;
      end else begin
        ovalid <= 1'b0;
      end
    end
  end

  assign rd_flag  = fall_mode ? ~ovalid : ~ram_empty;
  assign aempty_n = ~(rcount <= PW'(ae_off));

  AST_EMPTY_IGNORES_READ: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && ram_empty) |=> (rbin == $past(rbin))) else $error("read pointer moved while empty"); // R6
  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) rcount <= PW'(DEPTH)) else $error("read count beyond depth"); // R5
  AST_HEAD_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (fall_mode && ovalid && !rd_en) |=> ovalid) else $error("head word dropped without acknowledge"); // R4
  AST_MODE_FROZEN_R: assert property (@(posedge clk) disable iff (!mrst_n) mrst_n |=> $stable(mode)) else $error("read-side mode changed outside master reset"); // R1
endmodule

// File: rtl/tcf_fifo.sv
module tcf_fifo #(
  parameter int DW = 9,
  parameter int AW = 4
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          ft_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic [AW-1:0] ae_off,
  input  logic [AW-1:0] af_off,
  output logic          wr_flag,
  output logic          rd_flag,
  output logic          half_n,
  output logic          aempty_n,
  output logic          afull_n
);
  localparam int PW = AW + 1;

  logic          rst_n;
  logic          push;
  logic          ram_re;
  logic          fall_mode;
  logic [AW-1:0] waddr;
  logic [AW-1:0] raddr;
  logic [PW-1:0] wgray;
  logic [PW-1:0] rgray;
  logic [PW-1:0] wgray_s;
  logic [PW-1:0] rgray_s;

  // both resets clear data; only master reset reloads the mode
  assign rst_n = mrst_n & prst_n;

  tcf_sync2 #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
  tcf_sync2 #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

  tcf_wside #(.AW(AW)) u_wside (
    .clk(wr_clk), .mrst_n(mrst_n), .rst_n(rst_n), .ft_sel(ft_sel),
    .wr_en(wr_en), .af_off(af_off), .rgray_s(rgray_s),
    .waddr(waddr), .push(push), .wgray(wgray),
    .wr_flag(wr_flag), .afull_n(afull_n), .half_n(half_n)
  );

  tcf_rside #(.AW(AW)) u_rside (
    .clk(rd_clk), .mrst_n(mrst_n), .rst_n(rst_n), .ft_sel(ft_sel),
    .rd_en(rd_en), .ae_off(ae_off), .wgray_s(wgray_s),
    .ram_re(ram_re), .raddr(raddr), .rgray(rgray),
    .fall_mode(fall_mode), .rd_flag(rd_flag), .aempty_n(aempty_n)
  );

  tcf_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wr_clk), .we(push), .waddr(waddr), .wdata(wr_data),
    .rclk(rd_clk), .re(ram_re), .raddr(raddr), .rdata(rd_data)
  );

  AST_STD_DATA_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n) (!fall_mode && !rd_en) |=> $stable(rd_data)) else $error("standard output changed without a read"); // R3
  AST_FALL_HEAD_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n) (fall_mode && !rd_flag && !rd_en) |=> ($stable(rd_data) && !rd_flag)) else $error("fall-through head changed without acknowledge"); // R4
endmodule

// File: tb/test_tcf_fifo.sv
`timescale 1ns/1ps
module test_tcf_fifo;
  localparam int DW = 9;
  localparam int AW = 4;
  localparam int D  = 1 << AW;
  localparam int AE = 2;
  localparam int AF = 3;

  logic wr_clk = 0, rd_clk = 0;
  always #2 wr_clk = ~wr_clk;   // 250 MHz
  always #3 rd_clk = ~rd_clk;

  logic          mrst_n = 0, prst_n = 1, ft_sel = 0, wr_en = 0, rd_en = 0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] ae_off = AW'(AE), af_off = AW'(AF);
  logic          wr_flag, rd_flag, half_n, aempty_n, afull_n;

  int checks = 0, failures = 0;
  bit fall = 0;
  logic [DW-1:0] model[$];

  tcf_fifo #(.DW(DW), .AW(AW)) i_tcf_fifo (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n), .ft_sel(ft_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .ae_off(ae_off), .af_off(af_off), .wr_flag(wr_flag), .rd_flag(rd_flag),
    .half_n(half_n), .aempty_n(aempty_n), .afull_n(afull_n)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected values from the requirements
  function automatic int cap();       return fall ? D + 1 : D; endfunction
  function automatic int arr(int n);  return (fall && n > 0) ? n - 1 : n; endfunction
  function automatic int e_wr(int n); return fall ? int'(n == D + 1) : int'(n < D); endfunction
  function automatic int e_rd(int n); return fall ? int'(n == 0) : int'(n > 0); endfunction
  function automatic int e_af(int n); return int'(!(arr(n) >= D - AF)); endfunction
  function automatic int e_ae(int n); return int'(!(arr(n) <= AE)); endfunction
  function automatic int e_hf(int n); return int'(!(arr(n) > D / 2)); endfunction

  task automatic settle();
    repeat (8) @(posedge rd_clk);
    repeat (8) @(posedge wr_clk);
    @(negedge wr_clk);
  endtask

  task automatic check_flags(string ctx);
    int n;
    n = model.size();
    chk({"R5 wr_flag ", ctx}, int'(wr_flag), e_wr(n));
    chk({"R3/R4 rd_flag ", ctx}, int'(rd_flag), e_rd(n));
    chk({"R7 afull_n ", ctx}, int'(afull_n), e_af(n));
    chk({"R8 aempty_n ", ctx}, int'(aempty_n), e_ae(n));
    chk({"R9 half_n ", ctx}, int'(half_n), e_hf(n));
  endtask

  task automatic do_mreset(bit m);
    @(negedge wr_clk);
    mrst_n = 0; ft_sel = m; wr_en = 0; rd_en = 0;
    repeat (4) @(posedge rd_clk);
    @(negedge wr_clk);
    mrst_n = 1;
    fall = m;
    model.delete();
    @(negedge wr_clk);
    ft_sel = ~m;   // R1: later changes must not matter
  endtask

  task automatic do_preset();
    @(negedge wr_clk);
    prst_n = 0; ft_sel = ~ft_sel;   // R1: toggled during partial reset
    repeat (3) @(posedge rd_clk);
    @(negedge wr_clk);
    prst_n = 1;
    model.delete();
  endtask

  task automatic push1(logic [DW-1:0] v);
    @(negedge wr_clk);
    wr_en = 1; wr_data = v;
    if (model.size() < cap()) model.push_back(v);
    @(negedge wr_clk);
    wr_en = 0;
  endtask

  task automatic pop_std(string tag);
    logic [DW-1:0] e;
    e = model.pop_front();
    @(negedge rd_clk); rd_en = 1;
    @(negedge rd_clk); rd_en = 0;
    chk(tag, int'(rd_data), int'(e));
  endtask

  task automatic pop_fall(string tag);
    @(negedge rd_clk);
    chk({tag, " ready"}, int'(rd_flag), 0);
    chk({tag, " head"}, int'(rd_data), int'(model[0]));
    void'(model.pop_front());
    rd_en = 1;
    @(negedge rd_clk); rd_en = 0;
  endtask

  task automatic traffic(int nwords, string tag);
    fork
      begin
        int sent = 0;
        while (sent < nwords) begin
          @(negedge wr_clk);
          if (($urandom % 4) != 0 && (fall ? (wr_flag == 0) : (wr_flag == 1))) begin
            wr_en = 1; wr_data = DW'($urandom);
            model.push_back(wr_data);
            sent++;
          end else wr_en = 0;
        end
        @(negedge wr_clk); wr_en = 0;
      end
      begin
        int got = 0;
        bit pend = 0;
        logic [DW-1:0] e = '0;
        while (got < nwords) begin
          @(negedge rd_clk);
          if (!fall) begin
            if (pend) begin chk({tag, " order"}, int'(rd_data), int'(e)); pend = 0; got++; end
            if (got < nwords && rd_flag && ($urandom % 3) != 0 && model.size() > 0) begin
              rd_en = 1; e = model.pop_front(); pend = 1;
            end else rd_en = 0;
          end else begin
            if (rd_flag == 0 && ($urandom % 3) != 0 && model.size() > 0) begin
              chk({tag, " head"}, int'(rd_data), int'(model[0]));
              void'(model.pop_front());
              rd_en = 1; got++;
            end else rd_en = 0;
          end
        end
        @(negedge rd_clk); rd_en = 0;
      end
    join
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [DW-1:0] last;
    // ---------- standard mode ----------
    do_mreset(0);
    settle();
    check_flags("R2 reset std");
    for (int i = 1; i <= D + 2; i++) begin
      push1(DW'(i * 7 + 3));
      settle();
      check_flags("std fill step");
    end
    while (model.size() > 0) pop_std("R3 std drain");
    last = rd_data;
    @(negedge rd_clk); rd_en = 1;
    repeat (3) @(negedge rd_clk);
    rd_en = 0;
    @(negedge rd_clk);
    chk("R6 std empty read keeps data", int'(rd_data), int'(last));
    push1(9'h1A5);
    settle();
    pop_std("R6 next word after empty reads");
    traffic(200, "R3 std random");
    settle();
    check_flags("R3 std after traffic");
    for (int i = 0; i < 5; i++) push1(DW'(i + 40));
    settle();
    do_preset();
    settle();
    check_flags("R10 std after partial reset");
    push1(9'h055);
    settle();
    chk("R10 R1 std mode kept", int'(rd_flag), 1);
    pop_std("R10 only new word after partial reset");

    // ---------- fall-through mode ----------
    do_mreset(1);
    settle();
    check_flags("R2 reset fall");
    push1(9'h0AB);
    settle();
    chk("R4 head shown without rd_en flag", int'(rd_flag), 0);
    chk("R4 head shown without rd_en data", int'(rd_data), 9'h0AB);
    for (int i = 2; i <= D + 3; i++) begin
      push1(DW'(i * 5 + 1));
      settle();
      check_flags("fall fill step");
    end
    while (model.size() > 0) pop_fall("R4 fall drain");
    settle();
    check_flags("R4 fall drained");
    @(negedge rd_clk); rd_en = 1;
    repeat (3) @(negedge rd_clk);
    rd_en = 0;
    push1(9'h133);
    settle();
    chk("R6 fall word after idle reads", int'(rd_data), 9'h133);
    pop_fall("R6 fall read");
    traffic(200, "R4 fall random");
    settle();
    check_flags("R4 fall after traffic");
    for (int i = 0; i < 3; i++) push1(DW'(i + 70));
    settle();
    do_preset();
    settle();
    check_flags("R10 fall after partial reset");
    push1(9'h0EE);
    settle();
    chk("R10 R1 fall mode kept flag", int'(rd_flag), 0);
    chk("R10 fall new head", int'(rd_data), 9'h0EE);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule